// File: doc/BRIEF.md
# Secondary Bus Reset Sequencer

This block drives the reset of a bridge's secondary bus. The secondary reset is held low while the primary bus reset is active or while the software reset control bit is set. When the request ends, the block keeps the secondary reset low and waits for an external clock-stable qualifier. It then opens a short capability-sampling window, with the strong pull-up enable on the capability pin driven high. It keeps the bus in reset until a programmable minimum time has passed since the qualifier was seen, and then releases it.

The clock-stable qualifier is trusted to rise only once per reset. After it has been accepted it is latched, and any later toggling is ignored until the next reset request. The qualifier may be tied high; sequencing then starts as soon as the reset request ends. The capability pin reaches the block as two digitised comparator outputs. Together with a static frequency-select strap, they are turned into a 2-bit bus mode code at the close of the sampling window. The analog network, the PLL and the clock source lie outside the block.

The primary reset `priRstN` also serves as the block's own asynchronous reset. The control bit `sbrBit` comes from a register in the same clock domain.

Top module: `secbus_reset_seq`

## Requirements
- R1: `secRstN` is 0 at once (asynchronously) while `priRstN` is 0, and from the first clock edge that samples `sbrBit` at 1 for as long as `sbrBit` stays 1.
- R2: `clkStableIn` passes through two flip-flops and is then latched. While the sequence waits, the sampling window begins 4 cycles after `clkStableIn` rises. If `clkStableIn` is already high and synchronised, the window begins 3 cycles after `sbrBit` is released. If it is low, no window begins.
- R3: `strongPuEn` is 1 for exactly `SAMPLE_CYCLES` consecutive cycles per sequence, only inside the sampling window, and never while `secRstN` is 1.
- R4: `secRstN` rises exactly `HOLD_CYCLES` cycles after the first cycle of the sampling window, which is the first cycle in which the latched clock-stable qualifier takes effect. `HOLD_CYCLES` must exceed `SAMPLE_CYCLES`.
- R5: Once the qualifier is latched, toggling `clkStableIn` does not change the window, the release time or the released state until the next reset request.
- R6: `modeCode` is 00 from reset until capture. It is captured from `capSense` on the last cycle of the window: `capSense[1]`=1 gives 10 when `freqSel100`=1 and 11 when `freqSel100`=0; otherwise `capSense[0]`=1 gives 01; otherwise it is 00 (conventional PCI, a single code for both clock speeds).
- R7: `seqDone` is 1 for exactly one cycle, the first cycle in which `secRstN` is 1.
- R8: A request through `sbrBit` in any phase restarts the sequence. The window ends, or the release is withdrawn, from the next cycle. `modeCode` returns to 00. After the request the qualifier must be seen again, and a full new window and hold follow.
- R9: `modeCode` does not change while `secRstN` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| priRstN | input | 1 | Primary bus reset, active low, asynchronous |
| sbrBit | input | 1 | Software secondary reset control bit, active high |
| clkStableIn | input | 1 | Secondary clock stable qualifier, asynchronous |
| capSense | input | 2 | Digitised capability comparators: bit 0 above low threshold, bit 1 above high threshold |
| freqSel100 | input | 1 | Static strap: 1 selects 100 MHz, 0 selects 133 MHz for fast capable buses |
| secRstN | output | 1 | Secondary bus reset, active low |
| strongPuEn | output | 1 | Strong pull-up enable during the capability window |
| modeCode | output | 2 | Sampled bus mode: 00 PCI, 01 66, 10 100, 11 133 |
| seqDone | output | 1 | One-cycle pulse on release of the secondary reset |

## Verification
The sequence is swept over every combination of the two comparator bits and the frequency strap. Each combination is run with the qualifier tied high, rising in the same cycle as the request ends, and rising several cycles later. These runs separate the decode of each mode code, and they separate the tied-high start point from the synchronised wait. Variants that toggle the qualifier after it is latched show whether the latch isolates the hold counter. Restarts placed in the wait, the window and the hold show that each phase is cleared and that the qualifier must be seen again. A primary reset dropped between clock edges shows the asynchronous path.

// File: rtl/secrst_pkg.sv
package secrst_pkg;

  typedef enum logic [2:0] {
    ST_REQ    = 3'd0,
    ST_WAIT   = 3'd1,
    ST_SAMPLE = 3'd2,
    ST_HOLD   = 3'd3,
    ST_RUN    = 3'd4
  } seqState_t;

  typedef struct packed {
    logic clrAll;
    logic armStable;
    logic clrCnt;
    logic incCnt;
    logic capture;
    logic done;
  } seqStrobe_t;

  localparam logic [1:0] MODE_PCI  = 2'b00;
  localparam logic [1:0] MODE_X66  = 2'b01;
  localparam logic [1:0] MODE_X100 = 2'b10;
  localparam logic [1:0] MODE_X133 = 2'b11;

  function automatic logic [1:0] decodeMode(input logic [1:0] cap, input logic sel100);
    logic [1:0] m;
    if (cap[1])      m = sel100 ? MODE_X100 : MODE_X133;
    else if (cap[0]) m = MODE_X66;
    else             m = MODE_PCI;
    return m;
  endfunction

endpackage

// File: rtl/secrst_sync.sv
module secrst_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  genvar b;
  generate
    for (b = 0; b < WIDTH; b++) begin : gBit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[STAGES-2:0], d[b]};
      end
      assign q[b] = chain[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/secrst_ctrl.sv
module secrst_ctrl
  import secrst_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sbrBit,
  input  logic       stableSeen,
  input  logic       sampleEnd,
  input  logic       holdEnd,
  output seqStrobe_t strb,
  output logic       strongPuEn,
  output logic       secRstN
);

  seqState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_REQ;
    else       state <= nextState;
  end

  always_comb begin
    strb      = '0;
    nextState = state;
    if (sbrBit) begin
      strb.clrAll = 1'b1;
      nextState   = ST_REQ;
    end else begin
      case (state)
        ST_REQ: begin
          strb.clrAll = 1'b1;
          nextState   = ST_WAIT;
        end
        ST_WAIT: begin
          strb.armStable = 1'b1;
          if (stableSeen) begin
            strb.clrCnt = 1'b1;
            nextState   = ST_SAMPLE;
          end
        end
        ST_SAMPLE: begin
          strb.incCnt = 1'b1;
          if (sampleEnd) begin
            strb.capture = 1'b1;
            nextState    = ST_HOLD;
          end
        end
        ST_HOLD: begin
          strb.incCnt = 1'b1;
          if (holdEnd) begin
            strb.done = 1'b1;
            nextState = ST_RUN;
          end
        end
        ST_RUN:  nextState = ST_RUN;
        default: nextState = ST_REQ;
      endcase
    end
  end

  assign strongPuEn = (state == ST_SAMPLE);
  assign secRstN    = (state == ST_RUN);

  // R1
  sbr_forces_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    sbrBit |=> !secRstN);

  // R3
  pu_not_released_chk: assert property (@(posedge clk) disable iff (!rstN)
    strongPuEn |-> !secRstN);

  // R2
  window_needs_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strongPuEn) |-> $past(stableSeen));

endmodule

// File: rtl/secrst_dp.sv
module secrst_dp
  import secrst_pkg::*;
#(
  parameter int SAMPLE_CYCLES = 16,
  parameter int HOLD_CYCLES   = 5000000
) (
  input  logic       clk,
  input  logic       rstN,
  input  seqStrobe_t strb,
  input  logic       stableSync,
  input  logic [1:0] capSync,
  input  logic       freqSel100,
  output logic       stableSeen,
  output logic       sampleEnd,
  output logic       holdEnd,
  output logic [1:0] modeCode,
  output logic       seqDone
);

  localparam int CNT_W = $clog2(HOLD_CYCLES + 1);
  localparam logic [CNT_W-1:0] SAMPLE_LAST = CNT_W'(SAMPLE_CYCLES - 1);
  localparam logic [CNT_W-1:0] HOLD_LAST   = CNT_W'(HOLD_CYCLES - 1);
  localparam logic [CNT_W-1:0] CNT_MAX     = CNT_W'(HOLD_CYCLES);

  logic [CNT_W-1:0] holdCnt;
  logic [1:0]       modeReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              stableSeen <= 1'b0;
    else if (strb.clrAll)                   stableSeen <= 1'b0;
    else if (strb.armStable && stableSync)  stableSeen <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                  holdCnt <= '0;
    else if (strb.clrAll || strb.clrCnt)        holdCnt <= '0;
    else if (strb.incCnt && holdCnt != CNT_MAX) holdCnt <= holdCnt + 1'b1;
  end

  assign sampleEnd = (holdCnt == SAMPLE_LAST);
  assign holdEnd   = (holdCnt >= HOLD_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             modeReg <= MODE_PCI;
    else if (strb.clrAll)  modeReg <= MODE_PCI;
    else if (strb.capture) modeReg <= decodeMode(capSync, freqSel100);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) seqDone <= 1'b0;
    else       seqDone <= strb.done;
  end

  assign modeCode = modeReg;

  // R5
  stable_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stableSeen && !strb.clrAll) |=> stableSeen);

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    holdCnt <= CNT_MAX);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    seqDone |=> !seqDone);

  // R9
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.capture && !strb.clrAll) |=> $stable(modeReg));

endmodule

// File: rtl/secbus_reset_seq.sv
module secbus_reset_seq
  import secrst_pkg::*;
#(
  parameter int SAMPLE_CYCLES = 16,
  parameter int HOLD_CYCLES   = 5000000
) (
  input  logic       clk,
  input  logic       priRstN,
  input  logic       sbrBit,
  input  logic       clkStableIn,
  input  logic [1:0] capSense,
  input  logic       freqSel100,
  output logic       secRstN,
  output logic       strongPuEn,
  output logic [1:0] modeCode,
  output logic       seqDone
);

  seqStrobe_t strb;
  logic       stableSync, stableSeen, sampleEnd, holdEnd;
  logic [1:0] capSync;

  secrst_sync #(.WIDTH(1), .STAGES(2)) uStableSync (
    .clk(clk), .rstN(priRstN), .d(clkStableIn), .q(stableSync)
  );

  secrst_sync #(.WIDTH(2), .STAGES(2)) uCapSync (
    .clk(clk), .rstN(priRstN), .d(capSense), .q(capSync)
  );

  secrst_ctrl uCtrl (
    .clk(clk), .rstN(priRstN), .sbrBit(sbrBit),
    .stableSeen(stableSeen), .sampleEnd(sampleEnd), .holdEnd(holdEnd),
    .strb(strb), .strongPuEn(strongPuEn), .secRstN(secRstN)
  );

  secrst_dp #(.SAMPLE_CYCLES(SAMPLE_CYCLES), .HOLD_CYCLES(HOLD_CYCLES)) uDp (
    .clk(clk), .rstN(priRstN), .strb(strb),
    .stableSync(stableSync), .capSync(capSync), .freqSel100(freqSel100),
    .stableSeen(stableSeen), .sampleEnd(sampleEnd), .holdEnd(holdEnd),
    .modeCode(modeCode), .seqDone(seqDone)
  );

  // R7
  done_with_release_chk: assert property (@(posedge clk) disable iff (!priRstN)
    $rose(secRstN) |-> seqDone);

endmodule

// File: tb/secbus_reset_seq_test.sv
module secbus_reset_seq_test;

  localparam int S = 6;
  localparam int H = 30;

  logic       clk = 1'b0;
  logic       priRstN, sbrBit, clkStableIn, freqSel100;
  logic [1:0] capSense;
  logic       secRstN, strongPuEn, seqDone;
  logic [1:0] modeCode;

  int cyc = 0;
  int errors = 0;
  int checks = 0;
  bit finished = 0;

  secbus_reset_seq #(.SAMPLE_CYCLES(S), .HOLD_CYCLES(H)) uut (
    .clk(clk), .priRstN(priRstN), .sbrBit(sbrBit), .clkStableIn(clkStableIn),
    .capSense(capSense), .freqSel100(freqSel100),
    .secRstN(secRstN), .strongPuEn(strongPuEn), .modeCode(modeCode), .seqDone(seqDone)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  function automatic int expMode(input logic [1:0] cap, input logic sel100);
    if (cap[1])      return sel100 ? 2 : 3;
    else if (cap[0]) return 1;
    else             return 0;
  endfunction

  // Follow one sequence from the current negedge; expStart is the cycle of
  // the first window cycle predicted from the requirements.
  task automatic measure(input int expStart, input logic [1:0] cap, input logic sel100,
                         input bit toggle, input string tag);
    int puFirst = -1, puCnt = 0, relFirst = -1, doneCnt = 0, doneAt = -1;
    int overlap = 0, modeAtRel = -1, dropped = 0;
    for (int i = 0; i < H + 24; i++) begin
      @(negedge clk);
      if (toggle && puFirst >= 0) clkStableIn = ~clkStableIn;
      if (strongPuEn) begin
        if (puFirst < 0) puFirst = cyc;
        puCnt++;
        if (secRstN) overlap++;
      end
      if (secRstN && relFirst < 0) begin
        relFirst = cyc;
        modeAtRel = modeCode;
      end
      if (relFirst >= 0 && !secRstN) dropped++;
      if (seqDone) begin
        doneCnt++;
        doneAt = cyc;
      end
    end
    check(puFirst == expStart, {"R2 window start ", tag}, puFirst, expStart);
    check(puCnt == S && overlap == 0, {"R3 window length ", tag}, puCnt, S);
    check(relFirst == puFirst + H, {"R4 release time ", tag}, relFirst, puFirst + H);
    check(doneCnt == 1 && doneAt == relFirst, {"R7 done pulse ", tag}, doneAt, relFirst);
    check(modeAtRel == expMode(cap, sel100), {"R6 mode code ", tag}, modeAtRel, expMode(cap, sel100));
    check(modeCode == modeAtRel && dropped == 0, {"R9 mode held R5 released ", tag}, modeCode, modeAtRel);
  endtask

  // delay < 0: qualifier tied high; otherwise it rises delay cycles after release
  task automatic runSeq(input int delay, input logic [1:0] cap, input logic sel100, input bit toggle);
    int c0, expStart;
    capSense = cap;
    freqSel100 = sel100;
    sbrBit = 1'b1;
    if (delay >= 0) clkStableIn = 1'b0;
    else            clkStableIn = 1'b1;
    repeat (4) @(negedge clk);
    check(secRstN == 1'b0 && strongPuEn == 1'b0, "R1 held during request", secRstN, 0);
    check(modeCode == 2'b00, "R8 mode cleared in request", modeCode, 0);
    sbrBit = 1'b0;
    c0 = cyc;
    if (delay >= 0) begin
      repeat (delay) @(negedge clk);
      clkStableIn = 1'b1;
      expStart = cyc + 4;
    end else begin
      expStart = c0 + 3;
    end
    measure(expStart, cap, sel100, toggle, toggle ? "toggled" : "steady");
  endtask

  initial begin
    #200000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    priRstN = 1'b0; sbrBit = 1'b0; clkStableIn = 1'b0; capSense = 2'b00; freqSel100 = 1'b0;
    #5;
    check(secRstN == 0 && strongPuEn == 0 && seqDone == 0, "R1 reset state", secRstN, 0);
    check(modeCode == 2'b00, "R6 reset mode", modeCode, 0);
    repeat (3) @(negedge clk);
    priRstN = 1'b1;
    repeat (10) @(negedge clk);
    check(strongPuEn == 0 && secRstN == 0, "R2 waits without qualifier", strongPuEn, 0);

    // Sweep comparators, strap and qualifier timing
    for (int d = -1; d <= 5; d += 3) begin
      for (int cp = 0; cp < 4; cp++) begin
        for (int fs = 0; fs < 2; fs++) begin
          runSeq((d < 0) ? -1 : ((d == 2) ? 0 : d), 2'(cp), 1'(fs), 1'b0);
        end
      end
    end

    // R5: toggling after latch is ignored
    runSeq(2, 2'b11, 1'b1, 1'b1);
    runSeq(-1, 2'b01, 1'b0, 1'b1);
    clkStableIn = 1'b1;

    // R8: restart during the window
    sbrBit = 1'b1; repeat (3) @(negedge clk);
    sbrBit = 1'b0;
    while (!strongPuEn) @(negedge clk);
    @(negedge clk);
    sbrBit = 1'b1;
    @(negedge clk);
    check(strongPuEn == 0 && secRstN == 0, "R8 window cut by request", strongPuEn, 0);

    // R8: restart during hold, qualifier must be seen again
    capSense = 2'b10; freqSel100 = 1'b0;
    repeat (3) @(negedge clk);
    sbrBit = 1'b0;
    while (!strongPuEn) @(negedge clk);
    while (strongPuEn) @(negedge clk);
    repeat (3) @(negedge clk);
    check(modeCode == 2'b11, "R6 mode visible in hold", modeCode, 3);
    sbrBit = 1'b1;
    clkStableIn = 1'b0;
    @(negedge clk);
    check(modeCode == 2'b00 && secRstN == 0, "R8 hold restart clears mode", modeCode, 0);
    repeat (3) @(negedge clk);
    sbrBit = 1'b0;
    repeat (8) @(negedge clk);
    check(strongPuEn == 0, "R8 qualifier required again", strongPuEn, 0);
    clkStableIn = 1'b1;
    measure(cyc + 4, 2'b10, 1'b0, 1'b0, "after restart");

    // R1: request while released, then asynchronous primary reset
    @(negedge clk);
    sbrBit = 1'b1;
    @(negedge clk);
    check(secRstN == 0, "R1 sbrBit withdraws release", secRstN, 0);
    sbrBit = 1'b0;
    measure(cyc + 3, 2'b10, 1'b0, 1'b0, "after sbr");
    #3 priRstN = 1'b0;
    #1 check(secRstN == 0 && modeCode == 0, "R1 async primary reset", secRstN, 0);
    @(negedge clk);
    priRstN = 1'b1;

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule